// File: doc/BRIEF.md
# Serial Shift Core with Selectable Clock Source

This block is an 8-bit serial shift register paired with a 4-bit edge counter. Both can be clocked by one of four sources, chosen by a two-bit select field. The sources are a software strobe, a single-cycle timer compare pulse, or the rising or falling edge of an external serial clock pin. In the external modes the counter advances on both edges of the pin. A strobe-bit level can hand the counter over to a separate software toggle strobe instead. When the counter wraps it sets a sticky overflow flag, and software clears that flag by writing one to it.

The register shifts left and takes the data-in value into bit 0. Bit 7 drives the data-out pin through an output latch. The latch behaves differently by source. With an external clock, the latch updates on the clock edge opposite to the sampling edge. With the software strobe or the timer, the latch is transparent.

The external clock and data pins each pass through a two-flop synchronizer before edge detection. All logic runs on the system clock `clk`.

Top module: `serial_shift_core`

## Requirements
- R1: After reset, `data_o` is 0x00, `cnt_o` is 0, `ovf_o` is 0 and `sdo` is 0.
- R2: With `src_sel`=00, each system-clock cycle in which `strb` is high shifts `data_o` left, taking the synchronized `sdi` into bit 0, and increments `cnt_o`. With `strb` low, neither changes. `ctog` and `tmatch` have no effect in this mode.
- R3: With `src_sel`=01, each cycle with `tmatch` high shifts and counts in the same way as R2. `strb` and `ctog` have no effect in this mode.
- R4: With `src_sel`=10 and `strb` low, a synchronized rising edge of `sck` shifts the register. Both rising and falling edges of `sck` increment `cnt_o`.
- R5: With `src_sel`=11 and `strb` low, a synchronized falling edge of `sck` shifts the register. Both edges of `sck` increment `cnt_o`.
- R6: With `src_sel[1]`=1 and `strb` high, `sck` edges no longer count. `cnt_o` increments once per cycle in which `ctog` is high, and the shift still follows `sck` as in R4 and R5.
- R7: With `src_sel[1]`=1, `sdo` takes register bit 7 only on the `sck` edge opposite to the shifting edge (falling for 10, rising for 11), and holds at all other times.
- R8: With `src_sel[1]`=0, `sdo` equals bit 7 of `data_o` in the same cycle in which the register changes.
- R9: When `cnt_o` wraps from 15 to 0, `ovf_o` is set and stays set until a cycle with `ovf_clr` high. A wrap in the same cycle as a clear leaves the flag set.
- R10: A change on `sck` or `sdi` present at clock edge k first takes effect in the register or counter at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Clock source select: 00 soft, 01 timer, 10 external rising, 11 external falling |
| strb | input | 1 | Soft shift strobe (mode 00); counter source select level (modes 1x) |
| ctog | input | 1 | Software counter toggle strobe, used in modes 1x with `strb` high |
| tmatch | input | 1 | Single-cycle timer compare pulse |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow flag |
| sdi | input | 1 | Serial data pin (asynchronous) |
| sck | input | 1 | External serial clock pin (asynchronous) |
| sdo | output | 1 | Serial data out through the output latch |
| data_o | output | 8 | Shift register contents |
| cnt_o | output | 4 | Edge counter value |
| ovf_o | output | 1 | Sticky counter overflow flag |

## Verification
Strobe, timer, toggle and clear inputs take effect on the first rising clock edge that samples them, so their results show at the next falling edge. A pin change needs two synchronizer stages plus the edge-detect flop, which puts its effect on the third rising edge; R10 is checked by looking at the counter after each of those three edges. The bench keeps a behavioural model that records pin history in queues and picks the sample from two edges back. On every falling edge, before it drives new inputs, the bench compares all four outputs with that model, so the combinational `sdo` path is checked against the select value that is in force at that moment.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT     = 2'b00,
    SRC_TIMER    = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } src_sel_e;

  function automatic logic f_is_ext(input logic [1:0] sel);
    return sel[1];
  endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ssc_clk_sel.sv
module ssc_clk_sel
  import ssc_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       strb,
  input  logic       tmatch,
  input  logic       ctog,
  input  logic       ext_rise,
  input  logic       ext_fall,
  output logic       shift_en,
  output logic       count_en,
  output logic       latch_upd,
  output logic       transparent
);
  logic pin_cnt;
  assign pin_cnt = strb ? ctog : (ext_rise | ext_fall);

  always_comb begin
    shift_en    = 1'b0;
    count_en    = 1'b0;
    latch_upd   = 1'b0;
    transparent = 1'b0;
    unique case (src_sel_e'(sel))
      SRC_SOFT: begin
        shift_en    = strb;
        count_en    = strb;
        transparent = 1'b1;
      end
      SRC_TIMER: begin
        shift_en    = tmatch;
        count_en    = tmatch;
        transparent = 1'b1;
      end
      SRC_EXT_RISE: begin
        shift_en  = ext_rise;
        count_en  = pin_cnt;
        latch_upd = ext_fall;
      end
      SRC_EXT_FALL: begin
        shift_en  = ext_fall;
        count_en  = pin_cnt;
        latch_upd = ext_rise;
      end
      default: ;
    endcase
  end

  // R4/R5: a shifting edge never also updates the latch
  always_comb begin
    a_r7_edges_disjoint: assert (!(shift_en && latch_upd && f_is_ext(sel)));
  end
endmodule

// File: rtl/ssc_shift_reg.sv
module ssc_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  input  logic              latch_upd,
  input  logic              transparent,
  output logic [DATA_W-1:0] data_q,
  output logic              sdo
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] f_shl(input logic [DATA_W-1:0] v,
                                              input logic b);
    return {v[MSB-1:0], b};
  endfunction

  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      lat_q  <= 1'b0;
    end else begin
      if (shift_en) data_q <= f_shl(data_q, din);
      if (transparent || latch_upd) lat_q <= data_q[MSB];
    end
  end

  assign sdo = transparent ? data_q[MSB] : lat_q;

  // R2: a shift moves every bit one place up and brings din into bit 0
  a_r2_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (data_q[MSB:1] == $past(data_q[MSB-1:0])) && (data_q[0] == $past(din)));
  // R2: no enable, no change
  a_r2_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(data_q));
endmodule

// File: rtl/ssc_edge_counter.sv
module ssc_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             wrap
);
  function automatic logic [CNT_W:0] f_inc(input logic [CNT_W-1:0] c);
    return {1'b0, c} + (CNT_W+1)'(1);
  endfunction

  logic [CNT_W:0] inc_res;
  assign inc_res = f_inc(cnt_q);
  assign wrap    = count_en & inc_res[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (count_en) cnt_q <= inc_res[CNT_W-1:0];
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  // R9: counting from all-ones lands on zero with the flag set
  a_r9_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && (cnt_q == '1)) |=> (ovf_q && (cnt_q == '0)));
  // R9: the flag stays set until cleared
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R9: the flag never rises without a wrap
  a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_q && !wrap) |=> !ovf_q);
  // R2: counter holds without an enable
  a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(cnt_q));
endmodule

// File: rtl/serial_shift_core.sv
module serial_shift_core
  import ssc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              strb,
  input  logic              ctog,
  input  logic              tmatch,
  input  logic              ovf_clr,
  input  logic              sdi,
  input  logic              sck,
  output logic              sdo,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o
);
  localparam int PIN_W = 2;

  logic [PIN_W-1:0] pins_s;
  logic sck_s, sdi_s, sck_d;
  logic ext_rise, ext_fall;
  logic shift_en, count_en, latch_upd, transparent, wrap;

  ssc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, sdi}), .q(pins_s)
  );
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign ext_rise = sck_s & ~sck_d;
  assign ext_fall = ~sck_s & sck_d;

  ssc_clk_sel u_sel (
    .sel(src_sel), .strb(strb), .tmatch(tmatch), .ctog(ctog),
    .ext_rise(ext_rise), .ext_fall(ext_fall),
    .shift_en(shift_en), .count_en(count_en),
    .latch_upd(latch_upd), .transparent(transparent)
  );

  ssc_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdi_s),
    .latch_upd(latch_upd), .transparent(transparent),
    .data_q(data_o), .sdo(sdo)
  );

  ssc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .ovf_clr(ovf_clr),
    .cnt_q(cnt_o), .ovf_q(ovf_o), .wrap(wrap)
  );

  // R2: soft mode with the strobe low leaves everything alone
  a_r2_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_SOFT && !strb) |=> ($stable(data_o) && $stable(cnt_o)));
  // R3: timer mode moves only on the compare pulse
  a_r3_timer_only: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_TIMER && !tmatch) |=> ($stable(data_o) && $stable(cnt_o)));
  // R6: with the strobe level high in external mode, only ctog counts
  a_r6_toggle_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (f_is_ext(src_sel) && strb && !ctog) |=> $stable(cnt_o));
  // R7: outside the opposite edge, the external-mode output holds
  a_r7_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (f_is_ext(src_sel) && !latch_upd) |=> (!f_is_ext(src_sel) || $stable(sdo)));
  // R4/R5: shifting in external mode requires a synchronized pin edge
  a_r4_shift_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (f_is_ext(src_sel) && !ext_rise && !ext_fall) |=> $stable(data_o));
  // R9: a wrap is visible as the flag one cycle later
  a_r9_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_o);
endmodule

// File: tb/serial_shift_core_tb.sv
module serial_shift_core_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic strb = 0, ctog = 0, tmatch = 0, ovf_clr = 0, sdi = 0, sck = 0;
  logic sdo, ovf_o;
  logic [7:0] data_o;
  logic [3:0] cnt_o;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  logic [7:0] m_reg = 8'h00;
  int         m_cnt = 0;
  logic       m_ovf = 0;
  logic       m_lat = 0;
  bit         sck_h[$];
  bit         sdi_h[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_core u_dut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .strb(strb), .ctog(ctog),
    .tmatch(tmatch), .ovf_clr(ovf_clr), .sdi(sdi), .sck(sck), .sdo(sdo),
    .data_o(data_o), .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  // model: pins are seen two recorded edges late, previous value one further back
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'h00; m_cnt = 0; m_ovf = 0; m_lat = 0;
      sck_h = {0, 0, 0};
      sdi_h = {0, 0, 0};
    end else begin
      bit s_now, s_old, d_in, up, dn, sh, ce, opp, tr, wr;
      s_now = sck_h[$-1];
      s_old = sck_h[$-2];
      d_in  = sdi_h[$-1];
      up = s_now && !s_old;
      dn = !s_now && s_old;
      sh = 0; ce = 0; opp = 0; tr = 0;
      case (src_sel)
        2'b00: begin sh = strb;   ce = strb;   tr = 1; end
        2'b01: begin sh = tmatch; ce = tmatch; tr = 1; end
        2'b10: begin sh = up; ce = strb ? ctog : (up || dn); opp = dn; end
        default: begin sh = dn; ce = strb ? ctog : (up || dn); opp = up; end
      endcase
      if (tr || opp) m_lat = m_reg[7];
      if (sh) m_reg = {m_reg[6:0], d_in};
      wr = 0;
      if (ce) begin
        wr = (m_cnt == 15);
        m_cnt = (m_cnt + 1) % 16;
      end
      if (wr) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      sck_h.push_back(sck);
      sdi_h.push_back(sdi);
      if (sck_h.size() > 6) begin void'(sck_h.pop_front()); void'(sdi_h.pop_front()); end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // wait for a falling edge, compare all outputs with the model
  task automatic tick();
    @(negedge clk);
    check(cur_req, "data_o", int'(data_o), int'(m_reg));
    check(cur_req, "cnt_o", int'(cnt_o), m_cnt);
    check("R9", "ovf_o", int'(ovf_o), int'(m_ovf));
    check(src_sel[1] ? "R7" : "R8", "sdo", int'(sdo),
          src_sel[1] ? int'(m_lat) : int'(m_reg[7]));
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_phase(input string req, input logic [1:0] sel, input int cycles,
                           input int sck_half, input int strb_mode);
    cur_req = req;
    src_sel = sel;
    for (int i = 0; i < cycles; i++) begin
      tick();
      lfsr = step_lfsr(lfsr);
      sdi    = lfsr[0];
      tmatch = lfsr[1] & lfsr[2];
      ctog   = lfsr[3];
      ovf_clr = (lfsr[7:4] == 4'h0);
      if (strb_mode == 2) strb = lfsr[5];
      else                strb = strb_mode[0];
      if (sck_half > 0 && (i % sck_half) == 0) sck = ~sck;
    end
    strb = 0; ctog = 0; tmatch = 0; ovf_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is held
    check("R1", "data_o reset", int'(data_o), 0);
    check("R1", "cnt_o reset", int'(cnt_o), 0);
    check("R1", "ovf_o reset", int'(ovf_o), 0);
    check("R1", "sdo reset", int'(sdo), 0);
    rst_n = 1;

    // R9 directed: 15 strobes, then the 16th wraps
    cur_req = "R9";
    src_sel = 2'b00;
    sdi = 1;
    repeat (3) tick();
    strb = 1;
    repeat (15) tick();
    check("R9", "cnt before wrap", int'(cnt_o), 15);
    check("R9", "ovf before wrap", int'(ovf_o), 0);
    tick();
    strb = 0;
    check("R9", "cnt after wrap", int'(cnt_o), 0);
    check("R9", "ovf after wrap", int'(ovf_o), 1);
    check("R2", "data after 16 ones", int'(data_o), 8'hFF);
    check("R8", "sdo transparent", int'(sdo), 1);
    repeat (3) tick();
    check("R9", "ovf sticky", int'(ovf_o), 1);
    ovf_clr = 1;
    tick();
    ovf_clr = 0;
    check("R9", "ovf cleared", int'(ovf_o), 0);

    // R10 directed: sck rise before edge k counts at edge k+2
    cur_req = "R10";
    src_sel = 2'b10;
    sck = 0;
    repeat (4) tick();
    c0 = int'(cnt_o);
    sck = 1;
    tick();
    check("R10", "cnt after edge k", int'(cnt_o), c0);
    tick();
    check("R10", "cnt after edge k+1", int'(cnt_o), c0);
    tick();
    check("R10", "cnt after edge k+2", int'(cnt_o), (c0 + 1) % 16);
    sck = 0;
    repeat (4) tick();

    run_phase("R2", 2'b00, 300, 0, 2);
    run_phase("R3", 2'b01, 300, 0, 2);
    run_phase("R4", 2'b10, 400, 3, 0);
    run_phase("R8", 2'b00, 50, 0, 2);
    run_phase("R5", 2'b11, 400, 4, 0);
    run_phase("R6", 2'b10, 300, 3, 1);
    run_phase("R6", 2'b11, 300, 5, 1);
    run_phase("R7", 2'b10, 200, 2, 0);
    run_phase("R3", 2'b01, 100, 3, 2);
    tick();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule